// File: doc/BRIEF.md
# Masked FP64 Exponent Lane Controller

This block takes a vector of 64-bit floating-point lanes and, for every lane that is switched on, produces the integer exponent floor(log2|x|) of the lane's value, encoded again as an FP64 number. Zero, infinity, NaN and subnormal inputs each get a fixed treatment. A flush-to-zero control makes subnormals behave as zero. Invalid and denormal status is gathered across the lanes that take part in the operation.

A lane controller sits around the per-lane exponent units. It chooses the active vector length (two, four or eight lanes). It applies a per-lane writemask, which can be overridden by a "no mask" control, and it chooses between merging and zeroing for lanes that are masked off. It can replicate the lowest source element into every lane when that element comes from memory. It clears every destination bit above the active length. A 4-bit reserved operand field must read all ones; any other value flags an undefined opcode and leaves the destination unchanged.

One operation is accepted per cycle through `start`. The new destination, the flags and the opcode status appear on registered outputs in the next cycle, marked by `valid_o`.

Top module: `vexp_lane_ctrl`

## Requirements
- R1: For a finite normal lane value with biased exponent e, the lane result is the FP64 encoding of the integer e-1023. The sign of the input does not matter, and an input of magnitude 1.0 gives +0.0 (all zero bits).
- R2: A zero lane value of either sign gives -INF (0xFFF0000000000000). An infinite value of either sign gives +INF (0x7FF0000000000000). A NaN returns its own bits with bit 51 forced to 1. A NaN whose bit 51 is 0 raises `flag_inv`.
- R3: A subnormal lane value gives the FP64 encoding of p-1074, where p is the index of the highest set bit among bits 51..0, and it raises `flag_den`. When `daz` is 1, a subnormal is handled as zero: the result is -INF and `flag_den` is not raised.
- R4: Lane j occupies destination bits [64j+63:64j]. `vlen_sel` 0, 1 and 2 select 2, 4 and 8 active lanes, and value 3 also selects 8. An active lane carries its computed result when `lane_mask[j]` is 1 or when `no_mask` is 1.
- R5: An active lane that is masked off keeps `old_dst` in that lane when `zero_mode` is 0, and becomes all zeros when `zero_mode` is 1.
- R6: When `bcast` and `src_mem` are both 1, every lane computes from `src_vec[63:0]`. When `src_mem` is 0, `bcast` has no effect.
- R7: All destination bits of lanes at or above the active lane count are zero, whatever the mask, `no_mask` and `zero_mode` say.
- R8: `flag_inv` and `flag_den` are the OR of the lane conditions over lanes that are both active and unmasked only.
- R9: When `rsvd_fld` is not 4'b1111, `undef_op` is 1, `dst_o` equals the `old_dst` given with that operation, and both flags are 0.
- R10: `valid_o` is 1 exactly in the cycle after a cycle with `start` high. The outputs hold their values between operations, and all outputs are zero after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Accept the operation presented this cycle |
| src_vec | input | 512 | Source vector, eight FP64 lanes |
| old_dst | input | 512 | Previous destination contents, used for merging |
| lane_mask | input | 8 | Per-lane writemask |
| no_mask | input | 1 | Treat every lane as unmasked |
| zero_mode | input | 1 | 1 zeroes masked-off lanes, 0 merges them |
| bcast | input | 1 | Replicate the lowest source element |
| src_mem | input | 1 | Source comes from memory (enables broadcast) |
| vlen_sel | input | 2 | Vector length: 0=128, 1=256, 2/3=512 bits |
| rsvd_fld | input | 4 | Reserved operand field, must be 4'b1111 |
| daz | input | 1 | Handle subnormal inputs as zero |
| valid_o | output | 1 | Result registers updated in the previous cycle |
| dst_o | output | 512 | New destination vector |
| flag_inv | output | 1 | Signalling NaN seen in a participating lane |
| flag_den | output | 1 | Subnormal seen in a participating lane |
| undef_op | output | 1 | Reserved field was illegal |

## Verification
Masking and length clearing both act on the same lane in the same cycle. The bench sets mask bits, merge mode and a nonzero old destination on lanes above a short vector length. The upper lanes must still read zero, and a signalling NaN placed there must not raise the invalid flag. The bench also combines broadcast with a sparse mask and zeroing. Every unmasked lane must then show the exponent of element 0, and every masked-off lane must read zero. A scoreboard model computes each expected vector with real-number conversion.

// File: rtl/vexp_pkg.sv
package vexp_pkg;
   localparam int FP_W      = 64;
   localparam int FRAC_W    = 52;
   localparam int EXP_W     = 11;
   localparam int EXP_BIAS  = 1023;
   localparam int SUB_SHIFT = 1074;
   localparam logic [FP_W-1:0] POS_INF = 64'h7FF0_0000_0000_0000;
   localparam logic [FP_W-1:0] NEG_INF = 64'hFFF0_0000_0000_0000;

   typedef struct packed {
      logic inv;
      logic den;
   } vexp_flags_t;
endpackage

// File: rtl/vexp_fp64_unit.sv
module vexp_fp64_unit
   import vexp_pkg::*;
(
   input  logic [FP_W-1:0] x,
   input  logic            daz,
   output logic [FP_W-1:0] y,
   output vexp_flags_t     flg
);
   logic [EXP_W-1:0]  bexp;
   logic [FRAC_W-1:0] frac;
   logic [5:0]        lead;
   logic              sub;
   logic signed [12:0] k;
   logic [10:0]       mag;
   logic [3:0]        q;
   logic [FRAC_W-1:0] mfrac;
   logic [FP_W-1:0]   conv;

   assign bexp = x[62:52];
   assign frac = x[51:0];
   assign sub  = (bexp == '0) && (frac != '0) && !daz;

   always_comb begin
      lead = '0;
      for (int b = 0; b < FRAC_W; b++)
         if (frac[b]) lead = 6'(b);
   end

   always_comb begin
      if (sub) k = $signed({7'b0, lead}) - 13'sd1074;
      else     k = $signed({2'b0, bexp}) - 13'sd1023;
      mag = k[12] ? 11'(-k) : 11'(k);
   end

   always_comb begin
      q = '0;
      for (int b = 0; b < 11; b++)
         if (mag[b]) q = 4'(b);
   end

   assign mfrac = 52'(mag) << (6'd52 - {2'b0, q});
   assign conv  = (mag == '0) ? '0 : {k[12], 11'd1023 + {7'b0, q}, mfrac};

   always_comb begin
      flg = '0;
      if (bexp == '1) begin
         if (frac != '0) begin
            y       = x | (64'd1 << 51);
            flg.inv = !frac[51];
         end else begin
            y = POS_INF;
         end
      end else if (bexp == '0 && !sub) begin
         y = NEG_INF;
      end else begin
         y       = conv;
         flg.den = sub;
      end
   end
endmodule

// File: rtl/vexp_lane_mux.sv
module vexp_lane_mux
   import vexp_pkg::*;
#(
   parameter int LANE_W = 64
) (
   input  logic [LANE_W-1:0] res,
   input  logic [LANE_W-1:0] old,
   input  vexp_flags_t       flg_in,
   input  logic              active,
   input  logic              enabled,
   input  logic              zero_mode,
   output logic [LANE_W-1:0] out,
   output vexp_flags_t       flg_out
);
   always_comb begin
      if (!active)      out = '0;
      else if (enabled) out = res;
      else if (zero_mode) out = '0;
      else              out = old;
      flg_out = (active && enabled) ? flg_in : '0;
   end
endmodule

// File: rtl/vexp_lane_ctrl.sv
module vexp_lane_ctrl
   import vexp_pkg::*;
#(
   parameter int LANES  = 8,
   parameter int LANE_W = 64,
   parameter int RSVD_W = 4
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    start,
   input  logic [LANES*LANE_W-1:0] src_vec,
   input  logic [LANES*LANE_W-1:0] old_dst,
   input  logic [LANES-1:0]        lane_mask,
   input  logic                    no_mask,
   input  logic                    zero_mode,
   input  logic                    bcast,
   input  logic                    src_mem,
   input  logic [1:0]              vlen_sel,
   input  logic [RSVD_W-1:0]       rsvd_fld,
   input  logic                    daz,
   output logic                    valid_o,
   output logic [LANES*LANE_W-1:0] dst_o,
   output logic                    flag_inv,
   output logic                    flag_den,
   output logic                    undef_op
);
   localparam int VEC_W = LANES * LANE_W;

   if (LANE_W != FP_W) begin : g_bad_lane_w
      $error("vexp_lane_ctrl: LANE_W must equal 64");
   end
   if (LANES < 2 || (LANES & (LANES - 1)) != 0) begin : g_bad_lanes
      $error("vexp_lane_ctrl: LANES must be a power of two, at least 2");
   end
   if (RSVD_W < 1) begin : g_bad_rsvd
      $error("vexp_lane_ctrl: RSVD_W must be positive");
   end

   logic              legal;
   logic              use_bc;
   int unsigned       n_act;
   logic [VEC_W-1:0]  nxt;
   logic [LANES-1:0]  inv_v, den_v;

   assign legal  = (rsvd_fld == '1);
   assign use_bc = bcast && src_mem;

   always_comb begin
      n_act = 32'd2 << vlen_sel;
      if (n_act > LANES) n_act = LANES;
   end

   for (genvar j = 0; j < LANES; j++) begin : g_lane
      logic [LANE_W-1:0] elem, res;
      vexp_flags_t       fl_raw, fl_gated;

      assign elem = use_bc ? src_vec[LANE_W-1:0] : src_vec[j*LANE_W +: LANE_W];

      vexp_fp64_unit u_unit (
         .x   (elem),
         .daz (daz),
         .y   (res),
         .flg (fl_raw)
      );

      vexp_lane_mux #(.LANE_W(LANE_W)) u_mux (
         .res       (res),
         .old       (old_dst[j*LANE_W +: LANE_W]),
         .flg_in    (fl_raw),
         .active    (n_act > j),
         .enabled   (no_mask || lane_mask[j]),
         .zero_mode (zero_mode),
         .out       (nxt[j*LANE_W +: LANE_W]),
         .flg_out   (fl_gated)
      );

      assign inv_v[j] = fl_gated.inv;
      assign den_v[j] = fl_gated.den;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         valid_o  <= 1'b0;
         dst_o    <= '0;
         flag_inv <= 1'b0;
         flag_den <= 1'b0;
         undef_op <= 1'b0;
      end else begin
         valid_o <= start;
         if (start) begin
            undef_op <= !legal;
            dst_o    <= legal ? nxt : old_dst;
            flag_inv <= legal && (|inv_v);
            flag_den <= legal && (|den_v);
         end
      end
   end
endmodule

// File: rtl/vexp_lane_ctrl_chk.sv
module vexp_lane_ctrl_chk #(
   parameter int LANES  = 8,
   parameter int LANE_W = 64,
   parameter int RSVD_W = 4
) (
   input logic                    clk,
   input logic                    rst_n,
   input logic                    start,
   input logic [LANES*LANE_W-1:0] src_vec,
   input logic [LANES*LANE_W-1:0] old_dst,
   input logic [LANES-1:0]        lane_mask,
   input logic                    no_mask,
   input logic                    zero_mode,
   input logic                    bcast,
   input logic                    src_mem,
   input logic [1:0]              vlen_sel,
   input logic [RSVD_W-1:0]       rsvd_fld,
   input logic                    daz,
   input logic                    valid_o,
   input logic [LANES*LANE_W-1:0] dst_o,
   input logic                    flag_inv,
   input logic                    flag_den,
   input logic                    undef_op
);
   assert_valid_follows_start_R10: assert property (@(posedge clk) disable iff (!rst_n)
      start |=> valid_o);
   assert_no_spurious_valid_R10: assert property (@(posedge clk) disable iff (!rst_n)
      !start |=> !valid_o);
   assert_hold_between_ops_R10: assert property (@(posedge clk) disable iff (!rst_n)
      !start |=> $stable(dst_o) && $stable(flag_inv) && $stable(flag_den));
   assert_undef_matches_field_R9: assert property (@(posedge clk) disable iff (!rst_n)
      valid_o |-> (undef_op == ($past(rsvd_fld) != '1)));
   assert_undef_keeps_dest_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (valid_o && undef_op) |-> (dst_o == $past(old_dst)) && !flag_inv && !flag_den);
   assert_short_len_upper_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (valid_o && !undef_op && $past(vlen_sel) == 2'd0) |-> ((dst_o >> (2*LANE_W)) == '0));
   assert_zeroing_lane0_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (valid_o && !undef_op && $past(!no_mask && zero_mode && !lane_mask[0]))
      |-> (dst_o[LANE_W-1:0] == '0));
   assert_merging_lane0_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (valid_o && !undef_op && $past(!no_mask && !zero_mode && !lane_mask[0]))
      |-> (dst_o[LANE_W-1:0] == $past(old_dst[LANE_W-1:0])));
endmodule

bind vexp_lane_ctrl vexp_lane_ctrl_chk #(.LANES(LANES), .LANE_W(LANE_W), .RSVD_W(RSVD_W)) u_chk (.*);

// File: tb/tb_vexp_lane_ctrl.sv
`timescale 1ns/1ps
module tb_vexp_lane_ctrl;
   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         start = 1'b0;
   logic [511:0] src_vec = '0, old_dst = '0;
   logic [7:0]   lane_mask = '0;
   logic         no_mask = 1'b0, zero_mode = 1'b0, bcast = 1'b0, src_mem = 1'b0, daz = 1'b0;
   logic [1:0]   vlen_sel = 2'd2;
   logic [3:0]   rsvd_fld = 4'hF;
   logic         valid_o, flag_inv, flag_den, undef_op;
   logic [511:0] dst_o;

   int checks = 0, errors = 0;
   logic [511:0] last_dst = '0;

   typedef struct {
      logic [511:0] d;
      logic inv, den, ud;
      string tag;
   } exp_t;
   exp_t sb[$];

   always #2.5 clk = ~clk;

   vexp_lane_ctrl dut (.*);

   function automatic logic [63:0] mexp(input logic [63:0] x, input logic dz,
                                        output logic iv, output logic dn);
      int k;
      iv = 1'b0; dn = 1'b0;
      if (x[62:52] == 11'h7FF) begin
         if (x[51:0] != 0) begin
            iv = !x[51];
            return x | (64'd1 << 51);
         end
         return 64'h7FF0_0000_0000_0000;
      end
      if (x[62:52] == 0) begin
         if (x[51:0] == 0 || dz) return 64'hFFF0_0000_0000_0000;
         dn = 1'b1;
         k = 0;
         for (int b = 0; b < 52; b++) if (x[b]) k = b - 1074;
      end else begin
         k = int'(x[62:52]) - 1023;
      end
      return $realtobits(real'(k));
   endfunction

   task automatic op(input string tag, input logic [511:0] s, input logic [511:0] o,
                     input logic [7:0] m, input logic nm, input logic zm, input logic bc,
                     input logic mem, input logic [1:0] vl, input logic [3:0] rf, input logic dz);
      exp_t e;
      int n;
      n = (vl == 0) ? 2 : (vl == 1) ? 4 : 8;
      e.d = '0; e.inv = 0; e.den = 0; e.tag = tag;
      e.ud = (rf != 4'hF);
      if (e.ud) begin
         e.d = o;
      end else begin
         for (int j = 0; j < n; j++) begin
            logic [63:0] el, r;
            logic iv, dn;
            el = (bc && mem) ? s[63:0] : s[j*64 +: 64];
            r = mexp(el, dz, iv, dn);
            if (nm || m[j]) begin
               e.d[j*64 +: 64] = r;
               e.inv |= iv;
               e.den |= dn;
            end else if (!zm) begin
               e.d[j*64 +: 64] = o[j*64 +: 64];
            end
         end
      end
      @(negedge clk);
      src_vec = s; old_dst = o; lane_mask = m; no_mask = nm; zero_mode = zm;
      bcast = bc; src_mem = mem; vlen_sel = vl; rsvd_fld = rf; daz = dz;
      start = 1'b1;
      sb.push_back(e);
   endtask

   task automatic idle(input int n);
      for (int i = 0; i < n; i++) begin
         @(negedge clk);
         start = 1'b0;
      end
   endtask

   always @(negedge clk) begin
      if (rst_n && valid_o) begin
         checks++;
         if (sb.size() == 0) begin
            errors++;
            $display("FAIL R10 unexpected valid_o: actual 1 expected 0");
         end else begin
            exp_t e;
            e = sb.pop_front();
            last_dst = e.d;
            if (dst_o !== e.d || flag_inv !== e.inv || flag_den !== e.den || undef_op !== e.ud) begin
               errors++;
               $display("FAIL %s: actual dst=%h inv=%b den=%b ud=%b expected dst=%h inv=%b den=%b ud=%b",
                        e.tag, dst_o, flag_inv, flag_den, undef_op, e.d, e.inv, e.den, e.ud);
            end
         end
      end
   end

   initial begin
      #(200000 * 5);
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   localparam logic [63:0] ONE = 64'h3FF0_0000_0000_0000, EIGHT = 64'h4020_0000_0000_0000,
      QTR = 64'h3FD0_0000_0000_0000, NEG3 = 64'hC008_0000_0000_0000,
      MINN = 64'h0010_0000_0000_0000, MAXN = 64'h7FEF_FFFF_FFFF_FFFF,
      PZ = 64'h0, NZ = 64'h8000_0000_0000_0000, PINF = 64'h7FF0_0000_0000_0000,
      NINF = 64'hFFF0_0000_0000_0000, QNAN = 64'h7FF8_0000_0000_0001,
      SNAN = 64'hFFF0_0000_0000_0005, DMIN = 64'h0000_0000_0000_0001,
      DMAX = 64'h000F_FFFF_FFFF_FFFF, BIG = 64'h7E37_E43C_8800_759C;
   localparam logic [511:0] OLD = {8{64'hA5A5_5A5A_0F0F_F0F0}};

   initial begin
      idle(3);
      rst_n = 1'b1;
      @(negedge clk);
      checks++;
      if (valid_o !== 0 || dst_o !== '0 || flag_inv !== 0 || flag_den !== 0 || undef_op !== 0) begin
         errors++;
         $display("FAIL R10 reset state: actual v=%b dst=%h expected all zero", valid_o, dst_o);
      end
      // R1 normal values, all lanes enabled by no_mask
      op("R1 normals", {BIG, MAXN, MINN, NEG3, QTR, EIGHT, ONE, ONE}, OLD, 8'h00, 1, 0, 0, 0, 2'd2, 4'hF, 0);
      // R2 specials including signalling NaN
      op("R2 specials", {SNAN, QNAN, NINF, PINF, NZ, PZ, ONE, EIGHT}, OLD, 8'hFF, 0, 0, 0, 0, 2'd2, 4'hF, 0);
      // R3 subnormals with denormal flag
      op("R3 subnormal", {DMAX, DMIN, {48'h0, 16'h8000}, ONE, ONE, ONE, DMIN, DMAX}, OLD, 8'hFF, 0, 0, 0, 0, 2'd3, 4'hF, 0);
      // R3 DAZ flushes subnormal
      op("R3 daz", {DMAX, DMIN, ONE, ONE, ONE, ONE, DMIN, DMAX}, OLD, 8'hFF, 0, 0, 0, 0, 2'd2, 4'hF, 1);
      idle(2);
      // R4 R5 merge masking
      op("R5 merge", {8{EIGHT}}, OLD, 8'hA5, 0, 0, 0, 0, 2'd2, 4'hF, 0);
      op("R5 zeroing", {8{EIGHT}}, OLD, 8'h5A, 0, 1, 0, 0, 2'd2, 4'hF, 0);
      // R8 masked-off signalling NaN and subnormal do not raise flags
      op("R8 masked flags", {SNAN, DMIN, ONE, ONE, ONE, ONE, ONE, ONE}, OLD, 8'h3F, 0, 0, 0, 0, 2'd2, 4'hF, 0);
      // R6 broadcast from memory
      op("R6 broadcast mem", {SNAN, ONE, ONE, ONE, ONE, ONE, ONE, QTR}, OLD, 8'hFF, 0, 0, 1, 1, 2'd2, 4'hF, 0);
      // R6 broadcast ignored for register source
      op("R6 broadcast reg", {EIGHT, ONE, NEG3, ONE, EIGHT, ONE, NEG3, QTR}, OLD, 8'hFF, 0, 0, 1, 0, 2'd2, 4'hF, 0);
      idle(1);
      // R7 R8 short length, merge mode, SNaN above length
      op("R7 len128 merge", {SNAN, SNAN, DMIN, DMIN, ONE, ONE, EIGHT, QTR}, OLD, 8'hFE, 0, 0, 0, 0, 2'd0, 4'hF, 0);
      op("R4 len256", {SNAN, SNAN, SNAN, SNAN, NEG3, DMIN, EIGHT, QTR}, OLD, 8'hFF, 0, 0, 0, 0, 2'd1, 4'hF, 0);
      // R6 R7 broadcast with sparse mask, zeroing and short length in one op
      op("R7 bcast+zero+len", {8{ONE}} | 512'(MINN), OLD, 8'hF6, 0, 1, 1, 1, 2'd1, 4'hF, 0);
      // R9 illegal reserved field
      op("R9 reserved", {8{SNAN}}, OLD, 8'hFF, 1, 0, 0, 0, 2'd2, 4'hE, 0);
      op("R9 reserved zero", {8{ONE}}, ~OLD, 8'h00, 0, 1, 0, 0, 2'd0, 4'h0, 0);
      idle(4);
      checks++;
      if (dst_o !== last_dst || valid_o !== 0) begin
         errors++;
         $display("FAIL R10 hold: actual dst=%h v=%b expected dst=%h v=0", dst_o, valid_o, last_dst);
      end
      checks++;
      if (sb.size() != 0) begin
         errors++;
         $display("FAIL R10 missing results: actual pending=%0d expected 0", sb.size());
      end
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule